// File: doc/BRIEF.md
# One-Second Reference Pulse Generator

This block produces a one-second timing wave from an 8 kHz reference that is asynchronous to the system clock. It brings the reference into the system clock domain and turns each rising edge of the reference into a single-cycle enable. A divider counts these enables and produces a square wave with a one-second period that is high for half of its cycle.

Each low-to-high transition of that wave sets a sticky status flag. When software enables it, the flag drives an interrupt line. The same transition can also send a one-cycle update strobe to the performance counters, but only when the two-bit update-mode field has its upper bit set. Software clears the flag by writing a one, and a new transition arriving in the same cycle as the clear keeps the flag set.

Top module: `onesec_ref`

## Requirements
- R1: The reference passes through two synchroniser flops and an edge detector. Each rising edge of `ref_8k` advances the divider exactly once. The resulting change on the outputs appears at the third rising `clk` edge after `ref_8k` rises.
- R2: `sec_out` is low for DIVIDE/2 reference edges and then high for DIVIDE/2 edges, and this repeats. The first rise comes after DIVIDE/2 edges counted from reset.
- R3: Every low-to-high transition of `sec_out` sets `sec_flag` in the same cycle.
- R4: `irq` equals `sec_flag` while `irq_en` is 1, and stays 0 while `irq_en` is 0.
- R5: `pm_update` pulses on a low-to-high transition of `sec_out` only when `upd_mode[1]` is 1 (modes 2'b10 and 2'b11). In modes 2'b00 and 2'b01 it never pulses.
- R6: Each `pm_update` pulse is exactly one `clk` cycle wide.
- R7: A one-cycle pulse on `flag_clr` clears `sec_flag` on the next edge. If a transition of `sec_out` sets the flag at that same edge, the flag stays 1.
- R8: While `rst_n` is low, the divider count is zero, and `sec_out`, `sec_flag`, `irq` and `pm_update` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_8k | input | 1 | 8 kHz reference, asynchronous to clk |
| flag_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| irq_en | input | 1 | Interrupt enable |
| upd_mode | input | 2 | Performance-update mode; bit 1 gates the strobe |
| sec_out | output | 1 | One-second square wave, 50% duty cycle |
| sec_flag | output | 1 | Sticky flag set on each rising edge of sec_out |
| irq | output | 1 | Interrupt request |
| pm_update | output | 1 | One-cycle performance-update strobe |

## Verification
A rising edge of the reference reaches `sec_out`, `sec_flag` and `pm_update` at the third `clk` edge, because it passes two synchroniser stages and the edge-detect flop. `irq` follows `sec_flag` in the same cycle. The bench drives inputs on falling edges and holds each reference phase for four clocks before it samples, so every output is settled when it is read. For the collision case, the clear pulse is placed so that it covers exactly that third edge. The strobe is counted and its width is checked on every falling edge, and the count is compared with the number of rises expected from the number of reference edges.

// File: rtl/onesec_ref.sv
module onesec_ref #(
  parameter int DIVIDE = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_8k,
  input  logic       flag_clr,
  input  logic       irq_en,
  input  logic [1:0] upd_mode,
  output logic       sec_out,
  output logic       sec_flag,
  output logic       irq,
  output logic       pm_update
);
  localparam int HALF = DIVIDE / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [1:0]    sync_q;
  logic          ref_d;
  logic [CW-1:0] cnt;
  logic          tick, wrap, sec_rise;

  assign tick     = sync_q[1] & ~ref_d;
  assign wrap     = tick && (cnt == LAST);
  assign sec_rise = wrap && !sec_out;
  assign irq      = sec_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      ref_d     <= 1'b0;
      cnt       <= '0;
      sec_out   <= 1'b0;
      sec_flag  <= 1'b0;
      pm_update <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], ref_8k};
      ref_d     <= sync_q[1];
      pm_update <= sec_rise & upd_mode[1];
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) sec_out <= ~sec_out;
      if (sec_rise)      sec_flag <= 1'b1;
      else if (flag_clr) sec_flag <= 1'b0;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_cnt_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_flag_set_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_flag) |-> $rose(sec_out));

  assert_flag_clear_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_flag) |-> $past(flag_clr));

  assert_strobe_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pm_update |-> ($rose(sec_out) && $past(upd_mode[1])));

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pm_update |=> !pm_update);

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/onesec_ref_tb.sv
module onesec_ref_tb;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_8k = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic [1:0] upd_mode = 2'b00;
  logic       sec_out, sec_flag, irq, pm_update;

  int checks = 0, fails = 0;
  int ticks = 0;
  int pm_cnt = 0, pm_width_err = 0;
  int pm_exp = 0;
  bit flag_exp = 0;
  bit pm_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  onesec_ref #(.DIVIDE(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_8k(ref_8k), .flag_clr(flag_clr),
    .irq_en(irq_en), .upd_mode(upd_mode), .sec_out(sec_out),
    .sec_flag(sec_flag), .irq(irq), .pm_update(pm_update)
  );

  always @(negedge clk) begin
    if (!rst_n) pm_prev <= 1'b0;
    else begin
      if (pm_update) pm_cnt <= pm_cnt + 1;
      if (pm_update && pm_prev) pm_width_err <= pm_width_err + 1;
      pm_prev <= pm_update;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, ticks);
    end
  endtask

  // one reference period; optional clear aligned with the third clk edge after ref rises
  task automatic ref_period(input bit clr_collide);
    bit rise;
    @(negedge clk) ref_8k = 1'b1;
    @(negedge clk);
    @(negedge clk) flag_clr = clr_collide;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk) ref_8k = 1'b0;
    repeat (4) @(negedge clk);
    ticks++;
    rise = (ticks % HALF == 0) && ((ticks / HALF) % 2 == 1);
    if (rise) begin
      flag_exp = 1'b1;
      if (upd_mode[1]) pm_exp++;
    end else if (clr_collide) flag_exp = 1'b0;
    check("R1/R2 sec_out", sec_out, (ticks / HALF) % 2);
    check("R3/R7 sec_flag", sec_flag, flag_exp);
    check("R4 irq", irq, flag_exp & irq_en);
  endtask

  task automatic plain_clear();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    flag_exp = 1'b0;
    check("R7 clear", sec_flag, 0);
    check("R4 irq after clear", irq, 0);
  endtask

  task automatic check_reset_state();
    check("R8 sec_out", sec_out, 0);
    check("R8 sec_flag", sec_flag, 0);
    check("R8 irq", irq, 0);
    check("R8 pm_update", pm_update, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // Phase A: strobe mode 2'b10, interrupt enabled
    irq_en = 1'b1; upd_mode = 2'b10;
    for (int i = 0; i < 2 * DIV; i++) ref_period(1'b0);
    check("R5 mode10 strobes", pm_cnt, pm_exp);
    check("R5 two rises seen", pm_exp, 2);

    // Phase B: modes 00/01 never strobe, interrupt masked, flag cleared each period
    irq_en = 1'b0;
    for (int m = 0; m < 2; m++) begin
      upd_mode = 2'(m);
      for (int i = 0; i < DIV; i++) begin
        ref_period(1'b0);
        if (flag_exp) check("R4 masked irq", irq, 0);
        plain_clear();
      end
    end
    check("R5 no strobe in modes 00/01", pm_cnt, pm_exp);

    // Phase C: mode 11, clear collides with every reference edge
    irq_en = 1'b1; upd_mode = 2'b11;
    for (int i = 0; i < 2 * DIV; i++) ref_period(1'b1);
    check("R5 mode11 strobes", pm_cnt, pm_exp);

    // Phase D: reset in mid-count
    for (int i = 0; i < HALF + 1; i++) ref_period(1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk) rst_n = 1'b1;
    ticks = 0; flag_exp = 1'b0;
    for (int i = 0; i < HALF; i++) ref_period(1'b0);
    check("R2 first rise after reset", sec_out, 1);

    repeat (2) @(negedge clk);
    check("R6 strobe width", pm_width_err, 0);
    check("R5 total strobes", pm_cnt, pm_exp);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule